// File: doc/BRIEF.md
# Flash Write-Mode Unlock Guard

This block sits beside a flash controller and watches its internal write bus for the two-write key that opens the flash writing modes. The key starts with a throwaway write to the flash control register. The data of that write becomes the key value. The very next bus access must be a write whose address and data both equal that key value. Both writes must target even addresses inside the active flash window. Any intervening access, or any write that does not fit the key, drops the detector back to idle.

Once the key completes, the block raises the write-mode status. It then loads a high-voltage settling timer that runs for ten microseconds, counted as ten times a parameter giving clock cycles per microsecond. While the timer runs, the ready flag stays low. An erase or program command that arrives during this window is discarded, and it sets a sticky error flag that a write-one-to-clear strobe removes. After the window, each command is acknowledged with a one-cycle accept pulse. A synchronous reset is the only way out of write mode.

Top module: `flash_unlock_guard`

## Requirements
- R1: While `rst` is high at a clock edge, `wmode`, `hv_ready`, `cmd_accept` and `seq_err` are all 0 after that edge.
- R2: Only a write whose address equals `CTRL_ADDR` can begin the key. Its data is kept as the key value, and a write to any other address leaves the detector idle.
- R3: When the bus access right after the first key write is a write with address equal to the key value and data equal to the key value, `wmode` reads 1 after that edge. If either the address or the data differs, `wmode` stays 0.
- R4: A key write at an odd address (bit 0 set) neither starts nor completes the key.
- R5: A key write whose address lies below `WIN_LO` or above `WIN_HI` (bounds inclusive) neither starts nor completes the key.
- R6: After the first key write, an `oth_en` strobe or any write that does not fit the key returns the detector to idle, even when `oth_en` and `wr_en` are high in the same cycle. A new control-register write is then needed.
- R7: Once set, `wmode` stays 1 until reset, whatever writes or other accesses follow.
- R8: `hv_ready` is 0 for exactly 10*`CLK_PER_US` clock cycles after `wmode` rises, and it is 1 from then on while `wmode` is 1.
- R9: A `cmd_en` pulse while `wmode` is 1 and `hv_ready` is 0 produces no `cmd_accept` and sets `seq_err`, which stays set. A `cmd_en` pulse outside write mode has no effect on either output.
- R10: A `cmd_en` pulse while `hv_ready` is 1 gives `cmd_accept` = 1 for exactly the cycle after it.
- R11: An `err_clr` pulse clears `seq_err`. If a new early command arrives in the same cycle, the set wins.
- R12: A reset during the settling window clears write mode, the timer and the error flag. A later unlock waits the full window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | W | Bus write address |
| wr_data | input | W | Bus write data |
| oth_en | input | 1 | Strobe for any bus cycle other than a write |
| cmd_en | input | 1 | Erase or program command strobe |
| err_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| wmode | output | 1 | Writing modes enabled |
| hv_ready | output | 1 | High-voltage settling done; first operation allowed |
| cmd_accept | output | 1 | One-cycle acknowledge of an accepted command |
| seq_err | output | 1 | Sticky flag set by a command issued too early |

## Verification
The hardest situation to reach is a key that fails on only one condition while every other condition holds. Examples are an even, in-window target whose data differs by one bit, or a correct second write that shares its cycle with an `oth_en` strobe. The bench builds a small instance with an 8-bit bus so that it can sweep every possible target value and every possible first-write address, each after a fresh reset. This covers the window edges and odd addresses on both sides of each bound. The same-cycle cases, such as a set racing a clear of the error flag or a command on the last cycle before ready, are reached by holding two strobes together for a single cycle at a counted offset from the unlock.

// File: rtl/flash_unlock_pkg.sv
package flash_unlock_pkg;

    // Settling window length in microseconds
    localparam int unsigned HV_SETTLE_US = 10;

    typedef enum logic [0:0] {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_st_e;

endpackage

// File: rtl/flash_unlock_addr_chk.sv
module flash_unlock_addr_chk #(
    parameter int unsigned W      = 16,
    parameter int unsigned WIN_LO = 'h1000,
    parameter int unsigned WIN_HI = 'h8FFF
) (
    input  logic [W-1:0] addr,
    output logic         ok
);
    localparam logic [W-1:0] LO_V = W'(WIN_LO);
    localparam logic [W-1:0] HI_V = W'(WIN_HI);

    // An address qualifies for the key when it is even and inside the window
    always_comb begin
        ok = (addr[0] == 1'b0) && (addr >= LO_V) && (addr <= HI_V);
    end
endmodule

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq
    import flash_unlock_pkg::*;
#(
    parameter int unsigned W         = 16,
    parameter int unsigned CTRL_ADDR = 'h1000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         oth_en,
    input  logic         addr_ok,
    output logic         wmode,
    output logic         unlock_now
);
    localparam logic [W-1:0] CTRL_V = W'(CTRL_ADDR);

    typedef struct packed {
        key_st_e      st;
        logic [W-1:0] key;
        logic         wm;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.wm) begin
            unique case (seq_q.st)
                KEY_IDLE: begin
                    if (wr_en && !oth_en && addr_ok && (wr_addr == CTRL_V)) begin
                        seq_d.st  = KEY_ARMED;
                        seq_d.key = wr_data;
                    end
                end
                KEY_ARMED: begin
                    if (oth_en) begin
                        seq_d.st = KEY_IDLE;
                    end else if (wr_en) begin
                        seq_d.st = KEY_IDLE;
                        if (addr_ok && (wr_addr == seq_q.key) && (wr_data == seq_q.key)) begin
                            seq_d.wm = 1'b1;
                        end
                    end
                end
                default: seq_d.st = KEY_IDLE;
            endcase
        end
        unlock_now = seq_d.wm && !seq_q.wm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{st: KEY_IDLE, key: '0, wm: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign wmode = seq_q.wm;

    // R7: write mode never drops without reset
    p_wmode_hold_r7: assert property (@(posedge clk) disable iff (rst)
        seq_q.wm |=> seq_q.wm);

    // R3: write mode only follows an armed detector
    p_unlock_from_armed_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_q.wm) |-> $past(seq_q.st == KEY_ARMED));

    // R6: an interrupting access disarms without unlocking
    p_abort_other_r6: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == KEY_ARMED && !seq_q.wm && oth_en) |=> (seq_q.st == KEY_IDLE && !seq_q.wm));
endmodule

// File: rtl/flash_unlock_hv_timer.sv
module flash_unlock_hv_timer
    import flash_unlock_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic wmode,
    input  logic unlock_now,
    input  logic cmd_en,
    input  logic err_clr,
    output logic hv_ready,
    output logic cmd_accept,
    output logic seq_err
);
    localparam int unsigned DLY    = HV_SETTLE_US * CLK_PER_US;
    localparam int unsigned CW     = $clog2(DLY + 1);
    localparam logic [CW-1:0] DLY_V = CW'(DLY);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          err;
        logic          acc;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic ready;
    logic early;

    always_comb begin
        ready = wmode && (tmr_q.cnt == '0);
        early = cmd_en && wmode && !ready;
        tmr_d = tmr_q;
        if (unlock_now) begin
            tmr_d.cnt = DLY_V;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
        tmr_d.acc = cmd_en && ready;
        if (early) begin
            tmr_d.err = 1'b1;
        end else if (err_clr) begin
            tmr_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '{cnt: '0, err: 1'b0, acc: 1'b0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign hv_ready   = ready;
    assign cmd_accept = tmr_q.acc;
    assign seq_err    = tmr_q.err;

    // R8: the settling counter is full on the first write-mode cycle
    p_load_on_unlock_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(wmode) |-> (tmr_q.cnt == DLY_V));

    // R10: an accept is only ever given for a command seen while ready
    p_accept_ready_r10: assert property (@(posedge clk) disable iff (rst)
        tmr_q.acc |-> $past(ready && cmd_en));

    // R9: an early command always leaves the error flag set
    p_early_err_r9: assert property (@(posedge clk) disable iff (rst)
        early |=> tmr_q.err);

    // R11: the error flag only drops on a clear strobe
    p_err_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (tmr_q.err && !err_clr) |=> tmr_q.err);
endmodule

// File: rtl/flash_unlock_guard.sv
module flash_unlock_guard
    import flash_unlock_pkg::*;
#(
    parameter int unsigned W          = 16,
    parameter int unsigned CTRL_ADDR  = 'h1000,
    parameter int unsigned WIN_LO     = 'h1000,
    parameter int unsigned WIN_HI     = 'h8FFF,
    parameter int unsigned CLK_PER_US = 50
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         oth_en,
    input  logic         cmd_en,
    input  logic         err_clr,
    output logic         wmode,
    output logic         hv_ready,
    output logic         cmd_accept,
    output logic         seq_err
);
    logic addr_ok;
    logic unlock_now;

    flash_unlock_addr_chk #(
        .W      (W),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI)
    ) u_chk (
        .addr (wr_addr),
        .ok   (addr_ok)
    );

    flash_unlock_seq #(
        .W         (W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .oth_en     (oth_en),
        .addr_ok    (addr_ok),
        .wmode      (wmode),
        .unlock_now (unlock_now)
    );

    flash_unlock_hv_timer #(
        .CLK_PER_US (CLK_PER_US)
    ) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .wmode      (wmode),
        .unlock_now (unlock_now),
        .cmd_en     (cmd_en),
        .err_clr    (err_clr),
        .hv_ready   (hv_ready),
        .cmd_accept (cmd_accept),
        .seq_err    (seq_err)
    );

    // R4: write mode is never reached through an odd target address
    p_no_odd_unlock_r4: assert property (@(posedge clk) disable iff (rst)
        unlock_now |-> (wr_addr[0] == 1'b0));

    // R1/R8: ready only with write mode
    p_ready_needs_wmode_r8: assert property (@(posedge clk) disable iff (rst)
        hv_ready |-> wmode);
endmodule

// File: tb/flash_unlock_guard_test.sv
module flash_unlock_guard_test;
    localparam int W   = 8;
    localparam int CA  = 'h50;
    localparam int LO  = 'h40;
    localparam int HI  = 'h7F;
    localparam int CPU = 1;
    localparam int DLY = 10 * CPU;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         oth_en = 1'b0;
    logic         cmd_en = 1'b0;
    logic         err_clr = 1'b0;
    logic         wmode, hv_ready, cmd_accept, seq_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    flash_unlock_guard #(
        .W(W), .CTRL_ADDR(CA), .WIN_LO(LO), .WIN_HI(HI), .CLK_PER_US(CPU)
    ) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .oth_en(oth_en), .cmd_en(cmd_en), .err_clr(err_clr),
        .wmode(wmode), .hv_ready(hv_ready), .cmd_accept(cmd_accept), .seq_err(seq_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic bus_wr(input int a, input int d);
        @(negedge clk); wr_en = 1'b1; wr_addr = W'(a); wr_data = W'(d);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic other();
        @(negedge clk); oth_en = 1'b1;
        @(negedge clk); oth_en = 1'b0;
    endtask

    task automatic cmd(input bit clr);
        @(negedge clk); cmd_en = 1'b1; err_clr = clr;
        @(negedge clk); cmd_en = 1'b0; err_clr = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic unlock();
        bus_wr(CA, 'h60);
        bus_wr('h60, 'h60);
    endtask

    function automatic bit key_ok(input int a);
        return (a % 2 == 0) && (a >= LO) && (a <= HI);
    endfunction

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        // R1 reset state
        do_reset();
        chk(wmode == 0, "R1 wmode", wmode, 0);
        chk(hv_ready == 0, "R1 hv_ready", hv_ready, 0);
        chk(cmd_accept == 0, "R1 cmd_accept", cmd_accept, 0);
        chk(seq_err == 0, "R1 seq_err", seq_err, 0);

        // R3 R4 R5: sweep every key value through both key writes
        for (int a = 0; a < 256; a++) begin
            do_reset();
            bus_wr(CA, a);
            bus_wr(a, a);
            chk(wmode == key_ok(a), "R3/R4/R5 key sweep", wmode, int'(key_ok(a)));
        end

        // R2: sweep every first-write address
        for (int a = 0; a < 256; a++) begin
            do_reset();
            bus_wr(a, 'h60);
            bus_wr('h60, 'h60);
            chk(wmode == (a == CA), "R2 first-write sweep", wmode, int'(a == CA));
        end

        // R3: data mismatch and address mismatch
        do_reset(); bus_wr(CA, 'h60); bus_wr('h60, 'h62);
        chk(wmode == 0, "R3 data mismatch", wmode, 0);
        do_reset(); bus_wr(CA, 'h60); bus_wr('h62, 'h60);
        chk(wmode == 0, "R3 address mismatch", wmode, 0);

        // R6: interruptions
        do_reset(); bus_wr(CA, 'h60); other(); bus_wr('h60, 'h60);
        chk(wmode == 0, "R6 other access", wmode, 0);
        bus_wr(CA, 'h60); bus_wr('h44, 'h44); bus_wr('h60, 'h60);
        chk(wmode == 0, "R6 stray write", wmode, 0);
        bus_wr(CA, 'h60);
        @(negedge clk); wr_en = 1'b1; oth_en = 1'b1; wr_addr = 'h60; wr_data = 'h60;
        @(negedge clk); wr_en = 1'b0; oth_en = 1'b0;
        chk(wmode == 0, "R6 same-cycle other", wmode, 0);
        unlock();
        chk(wmode == 1, "R6 restart after abort", wmode, 1);

        // R7: write mode holds
        bus_wr('h41, 'h13); other(); bus_wr(CA, 'h00);
        chk(wmode == 1, "R7 wmode held", wmode, 1);

        // R8: exact settling window
        do_reset(); unlock();
        chk(hv_ready == 0, "R8 ready at unlock", hv_ready, 0);
        for (int k = 1; k <= DLY + 2; k++) begin
            @(negedge clk);
            chk(hv_ready == (k >= DLY), "R8 window", hv_ready, int'(k >= DLY));
        end

        // R10: accepted command
        cmd(1'b0);
        chk(cmd_accept == 1, "R10 accept", cmd_accept, 1);
        chk(seq_err == 0, "R10 no error", seq_err, 0);
        @(negedge clk);
        chk(cmd_accept == 0, "R10 single pulse", cmd_accept, 0);

        // R9: outside write mode, no effect
        do_reset(); cmd(1'b0);
        chk(cmd_accept == 0, "R9 idle cmd accept", cmd_accept, 0);
        chk(seq_err == 0, "R9 idle cmd error", seq_err, 0);

        // R9: early command, last early cycle
        unlock();
        repeat (DLY - 2) @(negedge clk);
        chk(hv_ready == 0, "R9 still settling", hv_ready, 0);
        cmd(1'b0);
        chk(cmd_accept == 0, "R9 early not accepted", cmd_accept, 0);
        chk(seq_err == 1, "R9 error set", seq_err, 1);
        repeat (5) @(negedge clk);
        chk(seq_err == 1, "R9 error sticky", seq_err, 1);

        // R11: clear, then set-wins race
        clear();
        chk(seq_err == 0, "R11 clear", seq_err, 0);
        do_reset(); unlock(); cmd(1'b1);
        chk(seq_err == 1, "R11 set wins", seq_err, 1);

        // R12: reset mid-window, then full window again
        repeat (2) @(negedge clk);
        do_reset();
        chk(wmode == 0, "R12 wmode", wmode, 0);
        chk(hv_ready == 0, "R12 hv_ready", hv_ready, 0);
        chk(seq_err == 0, "R12 seq_err", seq_err, 0);
        unlock();
        for (int k = 1; k <= DLY; k++) begin
            @(negedge clk);
            chk(hv_ready == (k == DLY), "R12 full window", hv_ready, int'(k == DLY));
        end

        finish_up();
    end
endmodule